// File: doc/BRIEF.md
# Configurable Digital Input Glitch Filter

This block cleans up a single one-bit trigger input before other logic uses it. The raw input may be asynchronous to the local clock. An optional two-flop synchronizer brings it into the local domain. A filter stage then applies one of five behaviours, all sharing one 12-bit counter: pass-through, change-then-hold-off, symmetric debounce, or a debounce applied to only one edge direction, in either direction. A final XOR stage can invert the result.

All configuration pins are static. Each one is held constant while the block runs, and a change is made only together with a reset. The input is a level rather than a stream of items, so it has no valid/ready handshake. The filtered level is valid on every clock, and no back-pressure applies. The filtered state is a register. Every mode therefore adds one clock of latency, and the synchronizer adds two more when it is enabled.

Top module: `dgf_top`

## Requirements
- R1: While reset is asserted, the counter is cleared and the filtered state is 0, so `filt_out` equals `cfg_invert`.
- R2: Mode codes 000, 001, 010 and 011 pass the filter input to the filtered state one clock later. The counter is not used in these modes.
- R3: With `cfg_sync_en` = 1, the filter input is `trig_in` delayed by two local-clock flops. With `cfg_sync_en` = 0, the filter input is `trig_in` itself.
- R4: With `cfg_invert` = 1, `filt_out` is the complement of the filtered state. With `cfg_invert` = 0, `filt_out` equals the filtered state.
- R5: Mode 101 is the symmetric debounce. The filtered state takes a new level only after the filter input has differed from it on `cfg_len` consecutive clocks. A return to the current level before then clears the count.
- R6: Mode 100 is change-then-hold-off. A difference between the filter input and the state is copied to the state at once. Input changes on the following `cfg_len` clocks are then ignored.
- R7: Mode 111 qualifies only the high level. A low filter input clears the state on the next clock. A rise of the state needs `cfg_len` consecutive high clocks.
- R8: Mode 110 is the mirror of R7. A high filter input sets the state on the next clock. A fall of the state needs `cfg_len` consecutive low clocks.
- R9: A `cfg_len` of 0 makes modes 100, 101, 110 and 111 behave as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | 1 | Raw trigger input, asynchronous or synchronous |
| cfg_mode | input | 3 | Filter behaviour select (encoding in R2, R5 to R8) |
| cfg_len | input | 12 | Filter length in clocks |
| cfg_sync_en | input | 1 | 1 inserts the two-flop synchronizer |
| cfg_invert | input | 1 | 1 inverts the filtered output |
| filt_out | output | 1 | Filtered, optionally inverted, level |

## Verification
On every cycle, the assertions check five things:
- pass-through modes follow the input one clock later;
- the hold-off counter freezes the state;
- the single-direction modes react to their immediate edge at once;
- the debounce count stays below the length;
- a zero length degenerates to pass-through.

Only the bench scenarios can show the full behaviour. They do this by comparing glitch trains of growing width and pseudo-random data, one clock at a time, against a reference model. That covers the exact cycle on which a debounced edge is accepted, the end of a hold-off window, the synchronizer latency and the effect of inversion.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  typedef enum logic [2:0] {
    MODE_PASS   = 3'b000,
    MODE_RAPID  = 3'b100,
    MODE_DELAY  = 3'b101,
    MODE_STLOW  = 3'b110,
    MODE_STHIGH = 3'b111
  } dgf_mode_e;
endpackage

// File: rtl/dgf_sync_stage.sv
module dgf_sync_stage #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_en,
  input  logic raw_in,
  output logic sig_out
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_ff
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[gi] <= 1'b0;
        else        chain[gi] <= (gi == 0) ? raw_in : chain[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign sig_out = sync_en ? chain[STAGES-1] : raw_in;
endmodule

// File: rtl/dgf_filter_core.sv
module dgf_filter_core
  import dgf_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] len,
  input  logic             s_in,
  output logic             state_q
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             state_n;
  logic [EXT_W-1:0] cnt_inc;
  logic             fast_edge;

  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    fast_edge = 1'b0;
    case (mode)
      MODE_RAPID: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - CNT_W'(1);
        end else if (s_in != state_q) begin
          state_n = s_in;
          cnt_n   = len;
        end
      end
      MODE_DELAY, MODE_STLOW, MODE_STHIGH: begin
        fast_edge = (mode == MODE_STHIGH && !s_in) || (mode == MODE_STLOW && s_in);
        if (s_in == state_q) begin
          cnt_n = '0;
        end else if (fast_edge || cnt_inc >= {1'b0, len}) begin
          state_n = s_in;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_inc[CNT_W-1:0];
        end
      end
      default: begin
        state_n = s_in;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  // R2: non-counting codes follow the input one clock later
  assert_pass_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[2] |=> state_q == $past(s_in));

  // R6: an active hold-off window freezes the state
  assert_rapid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RAPID && cnt_q != '0) |=> $stable(state_q));

  // R7: low input clears the state at once in high-qualified mode
  assert_sthigh_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STHIGH && !s_in) |=> !state_q);

  // R8: high input sets the state at once in low-qualified mode
  assert_stlow_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STLOW && s_in) |=> state_q);

  // R5: debounce run length never reaches the configured length
  assert_delay_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DELAY && len != '0) |-> cnt_q < len);

  // R9: zero length with an idle counter behaves as pass-through
  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (len == '0 && cnt_q == '0) |=> state_q == $past(s_in));
endmodule

// File: rtl/dgf_top.sv
module dgf_top #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic [2:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_len,
  input  logic             cfg_sync_en,
  input  logic             cfg_invert,
  output logic             filt_out
);
  logic s_sig;
  logic state;

  dgf_sync_stage #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_en (cfg_sync_en),
    .raw_in  (trig_in),
    .sig_out (s_sig)
  );

  dgf_filter_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (cfg_mode),
    .len     (cfg_len),
    .s_in    (s_sig),
    .state_q (state)
  );

  assign filt_out = state ^ cfg_invert;
endmodule

// File: tb/dgf_top_tb_top.sv
module dgf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_in = 1'b0;
  logic [2:0]  cfg_mode = 3'b000;
  logic [11:0] cfg_len = 12'd0;
  logic        cfg_sync_en = 1'b0;
  logic        cfg_invert = 1'b0;
  logic        filt_out;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 0;
  string cur_req = "R1";
  bit exp_q[$];

  // reference model state
  bit m_f1, m_f2, m_q;
  int m_run, m_hold;

  always #5 clk = ~clk;

  dgf_top dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_mode(cfg_mode),
    .cfg_len(cfg_len), .cfg_sync_en(cfg_sync_en), .cfg_invert(cfg_invert),
    .filt_out(filt_out)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic check(input string req, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: filt_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // cycle model of one clock edge, derived from the requirements
  task automatic model_step(input bit d);
    bit s;
    int L;
    L = int'(cfg_len);
    s = cfg_sync_en ? m_f2 : d;
    m_f2 = m_f1;
    m_f1 = d;
    case (cfg_mode)
      3'b100: begin
        if (m_hold > 0) m_hold--;
        else if (s != m_q) begin m_q = s; m_hold = L; end
      end
      3'b101, 3'b110, 3'b111: begin
        if ((cfg_mode == 3'b111 && !s) || (cfg_mode == 3'b110 && s)) begin
          m_q = s; m_run = 0;
        end else if (s == m_q) m_run = 0;
        else begin
          m_run++;
          if (m_run >= L) begin m_q = s; m_run = 0; end
        end
      end
      default: m_q = s;
    endcase
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic apply(input bit v);
    trig_in = v;
    model_step(v);
    @(posedge clk);
    #1 exp_q.push_back(m_q ^ cfg_invert);
    @(negedge clk);
  endtask

  // monitor: compares results away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) check(cur_req, filt_out, exp_q.pop_front());
  end

  task automatic run_scenario(input logic [2:0] mode, input int len,
                              input bit sync, input bit inv, input string req);
    logic [7:0] lfsr;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_mode = mode;
    cfg_len = 12'(len);
    cfg_sync_en = sync;
    cfg_invert = inv;
    trig_in = 1'b0;
    m_f1 = 0; m_f2 = 0; m_q = 0; m_run = 0; m_hold = 0;
    #1 check("R1", filt_out, inv);  // R1: reset state seen at the output
    @(negedge clk);
    check("R1", filt_out, inv);
    rst_n = 1'b1;
    cur_req = req;
    for (int w = 1; w <= 6; w++) begin
      for (int k = 0; k < w; k++) apply(1'b1);
      for (int k = 0; k < w; k++) apply(1'b0);
    end
    for (int k = 0; k < 8; k++) apply(1'b1);
    for (int k = 0; k < 8; k++) apply(1'b0);
    lfsr = 8'hA5 ^ 8'(len) ^ {5'd0, mode};
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      apply(lfsr[0]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end

  initial begin
    run_scenario(3'b000, 5, 0, 0, "R2");  // plain pass-through
    run_scenario(3'b010, 5, 0, 0, "R2");  // unlisted code acts as pass-through
    run_scenario(3'b011, 2, 0, 1, "R4");  // pass-through, inverted
    run_scenario(3'b000, 0, 1, 0, "R3");  // synchronizer latency
    run_scenario(3'b101, 4, 0, 0, "R5");  // symmetric debounce
    run_scenario(3'b101, 3, 0, 1, "R4");  // debounce with inversion
    run_scenario(3'b100, 3, 0, 0, "R6");  // change then hold-off
    run_scenario(3'b111, 3, 0, 0, "R7");  // high-qualified
    run_scenario(3'b110, 3, 1, 0, "R8");  // low-qualified through synchronizer
    run_scenario(3'b101, 0, 0, 0, "R9");  // zero length debounce
    run_scenario(3'b100, 0, 0, 0, "R9");  // zero length hold-off
    run_scenario(3'b111, 0, 0, 1, "R9");  // zero length high-qualified
    @(negedge clk);
    summary();
  end
endmodule